// File: doc/BRIEF.md
# Secure-Gated Vectored Interrupt Controller

This block takes up to 32 level-sensitive interrupt lines and turns them into two request outputs for a processor: a fast request and a normal request. Every line first meets a per-line security gate that decides whether the line may take part at all. Out of reset the gate lets every line through. Lines that pass the gate and are enabled go either to the fast output, where they are simply ORed, or into a priority arbiter that drives the normal output.

Each normal-path line carries a 4-bit priority (0 is the most urgent) and a handler address. When the processor reads the vector register it gets the handler address of the current winner, and that winner's level is marked as in service. While a level is in service, lines at that level or at any less urgent level are held off, so only a more urgent line can break in. A write of any value to the vector register retires the most urgent level in service. Software can raise lines through a soft-trigger register. It can also block chosen levels with a level mask. An optional mode drops every register write that is not flagged as privileged.

Software reaches all of this over a simple single-cycle memory-mapped bus. Read data appears on the cycle after the read strobe.

Top module: `sec_vic`

## Requirements
- R1: After reset both request outputs are low, every gate bit reads 1, and enable, route, soft, level-mask and privileged-only all read 0.
- R2: A line whose gate bit (offset 0x020, bit = line index) is 0 reaches neither output nor either masked status, but still shows in raw status.
- R3: A line drives no output unless its enable bit is 1. Writing 1s at offset 0x00C sets enable bits, writing 1s at 0x010 clears them, and a read of 0x00C returns them.
- R4: A line whose route bit (offset 0x014) is 1 goes to the fast output, which is the OR of all gated, enabled, fast-routed lines and ignores priority, level mask and in-service state.
- R5: Among eligible normal lines, the smallest priority value wins, and the lower index breaks a tie. A read of the vector register (0x02C) returns the winner's handler address (0x100 + 4*index). Priority sits in bits [3:0] at 0x200 + 4*index.
- R6: A vector read with a winner marks the winner's level in service. From then on, only lines whose priority value is strictly below every in-service level may raise the normal output.
- R7: A write to the vector register clears only the most urgent (smallest) in-service level.
- R8: A 1 in level-mask bit L (offset 0x024) keeps lines of priority L off the normal output.
- R9: Writing 1s at offset 0x018 forces those lines active as if their inputs were high. Writing 1s at 0x01C removes them. A read of 0x018 returns the soft bits.
- R10: Raw status (0x000) is input OR soft, before gate and enable. Normal status (0x004) and fast status (0x008) show gated, enabled lines split by route.
- R11: When the privileged-only bit (0x028, bit 0) is 1, writes without the privileged flag change nothing.
- R12: A vector read with no eligible winner returns 0 and marks no level in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 32 | Level-sensitive interrupt lines |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 12 | Byte address |
| busWData | input | 32 | Write data |
| busPriv | input | 1 | Access is privileged |
| busRData | output | 32 | Read data, valid the cycle after busRd |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench goes after tie-breaking between equal priorities. It checks that the fast path takes no notice of priority, and that the claim/retire pairing still holds when interrupts nest. If retirement cleared every level instead of only the most urgent, the bench would see a held-off line raise the normal request too early. If it cleared the wrong level, a line would stay stuck low. The bench also reads the vector register with nothing pending and checks that this read marks no level in service, which would otherwise freeze the next request. A non-privileged write in privileged-only mode must leave the enable bits untouched, and so must a gate that has been closed.

// File: rtl/sec_vic_pkg.sv
package sec_vic_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  localparam logic [11:0] OFS_RAW    = 12'h000;
  localparam logic [11:0] OFS_IRQST  = 12'h004;
  localparam logic [11:0] OFS_FIQST  = 12'h008;
  localparam logic [11:0] OFS_ENSET  = 12'h00C;
  localparam logic [11:0] OFS_ENCLR  = 12'h010;
  localparam logic [11:0] OFS_ROUTE  = 12'h014;
  localparam logic [11:0] OFS_SSET   = 12'h018;
  localparam logic [11:0] OFS_SCLR   = 12'h01C;
  localparam logic [11:0] OFS_GATE   = 12'h020;
  localparam logic [11:0] OFS_LMASK  = 12'h024;
  localparam logic [11:0] OFS_PRIV   = 12'h028;
  localparam logic [11:0] OFS_VEC    = 12'h02C;
  localparam logic [3:0]  PAGE_HAND  = 4'h1;
  localparam logic [3:0]  PAGE_PRIO  = 4'h2;

  typedef enum logic [3:0] {
    RD_NONE, RD_RAW, RD_IRQST, RD_FIQST, RD_EN, RD_ROUTE, RD_SOFT,
    RD_GATE, RD_LMASK, RD_PRIV, RD_VEC, RD_HAND, RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic route;
    logic softSet;
    logic softClr;
    logic gate;
    logic lvlMask;
    logic vecAck;
    logic handWr;
    logic prioWr;
    logic claim;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/sec_vic_ctrl.sv
module sec_vic_ctrl
  import sec_vic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [11:0]       busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              busPriv,
  output strobe_t           stb,
  output rdSel_e            rdSel,
  output logic              privOnly
);
  logic              writeOk;
  logic [IDX_W-1:0]  pageIdx;
  logic              idxOk;
  logic              privWr;

  assign writeOk = busWr && (!privOnly || busPriv);
  assign pageIdx = IDX_W'(busAddr[7:2]);
  assign idxOk   = (int'(pageIdx) < NUM_SRC);

  always_comb begin
    stb      = '0;
    stb.data = busWData;
    stb.idx  = pageIdx;
    privWr   = 1'b0;
    if (writeOk) begin
      unique case (busAddr)
        OFS_ENSET: stb.enSet   = 1'b1;
        OFS_ENCLR: stb.enClr   = 1'b1;
        OFS_ROUTE: stb.route   = 1'b1;
        OFS_SSET:  stb.softSet = 1'b1;
        OFS_SCLR:  stb.softClr = 1'b1;
        OFS_GATE:  stb.gate    = 1'b1;
        OFS_LMASK: stb.lvlMask = 1'b1;
        OFS_PRIV:  privWr      = 1'b1;
        OFS_VEC:   stb.vecAck  = 1'b1;
        default: begin
          if (busAddr[11:8] == PAGE_HAND && idxOk) stb.handWr = 1'b1;
          if (busAddr[11:8] == PAGE_PRIO && idxOk) stb.prioWr = 1'b1;
        end
      endcase
    end
    stb.claim = busRd && (busAddr == OFS_VEC);
  end

  always_comb begin
    rdSel = RD_NONE;
    unique case (busAddr)
      OFS_RAW:   rdSel = RD_RAW;
      OFS_IRQST: rdSel = RD_IRQST;
      OFS_FIQST: rdSel = RD_FIQST;
      OFS_ENSET: rdSel = RD_EN;
      OFS_ROUTE: rdSel = RD_ROUTE;
      OFS_SSET:  rdSel = RD_SOFT;
      OFS_GATE:  rdSel = RD_GATE;
      OFS_LMASK: rdSel = RD_LMASK;
      OFS_PRIV:  rdSel = RD_PRIV;
      OFS_VEC:   rdSel = RD_VEC;
      default: begin
        if (busAddr[11:8] == PAGE_HAND && idxOk) rdSel = RD_HAND;
        if (busAddr[11:8] == PAGE_PRIO && idxOk) rdSel = RD_PRIO;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       privOnly <= 1'b0;
    else if (privWr) privOnly <= busWData[0];
  end

  // R11: an unprivileged write in privileged-only mode raises no write strobe
  assert_nonpriv_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && privOnly && !busPriv) |->
      !(stb.enSet || stb.enClr || stb.route || stb.softSet || stb.softClr ||
        stb.gate || stb.lvlMask || stb.vecAck || stb.handWr || stb.prioWr));

  assert_one_write_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.enSet, stb.enClr, stb.route, stb.softSet, stb.softClr,
              stb.gate, stb.lvlMask, stb.vecAck, stb.handWr, stb.prioWr}));
endmodule

// File: rtl/sec_vic_datapath.sv
module sec_vic_datapath
  import sec_vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            stb,
  input  rdSel_e             rdSel,
  input  logic               rdEn,
  input  logic               privOnly,
  output logic [DATA_W-1:0]  rData,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int LVLS = 1 << PRIO_W;

  logic [NUM_SRC-1:0] enReg, routeReg, softReg, gateReg;
  logic [LVLS-1:0]    lvlMaskReg, inService;
  logic [DATA_W-1:0]  handReg [NUM_SRC];
  logic [PRIO_W-1:0]  prioReg [NUM_SRC];

  logic [NUM_SRC-1:0] rawReq, passReq, irqReq, fiqReq, eligible;
  logic [PRIO_W-1:0]  ceilLvl, winPrio;
  logic [IDX_W-1:0]   winIdx;
  logic               winValid;
  logic [DATA_W-1:0]  rdMux;

  assign rawReq  = srcIn | softReg;
  assign passReq = rawReq & gateReg & enReg;
  assign irqReq  = passReq & ~routeReg;
  assign fiqReq  = passReq & routeReg;

  // most urgent in-service level
  always_comb begin
    ceilLvl = '0;
    for (int l = LVLS - 1; l >= 0; l--)
      if (inService[l]) ceilLvl = PRIO_W'(l);
  end

  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      eligible[i] = irqReq[i] && !lvlMaskReg[prioReg[i]] &&
                    (inService == '0 || prioReg[i] < ceilLvl);
      if (eligible[i] && (!winValid || prioReg[i] <= winPrio)) begin
        winValid = 1'b1;
        winPrio  = prioReg[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign irqOut = winValid;
  assign fiqOut = |fiqReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0; routeReg <= '0; softReg <= '0; gateReg <= '1;
      lvlMaskReg <= '0; inService <= '0;
    end else begin
      if (stb.enSet)   enReg      <= enReg | stb.data[NUM_SRC-1:0];
      if (stb.enClr)   enReg      <= enReg & ~stb.data[NUM_SRC-1:0];
      if (stb.route)   routeReg   <= stb.data[NUM_SRC-1:0];
      if (stb.softSet) softReg    <= softReg | stb.data[NUM_SRC-1:0];
      if (stb.softClr) softReg    <= softReg & ~stb.data[NUM_SRC-1:0];
      if (stb.gate)    gateReg    <= stb.data[NUM_SRC-1:0];
      if (stb.lvlMask) lvlMaskReg <= stb.data[LVLS-1:0];
      if (stb.claim && winValid)
        inService[winPrio] <= 1'b1;
      else if (stb.vecAck && inService != '0)
        inService[ceilLvl] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        handReg[g] <= '0;
        prioReg[g] <= '0;
      end else begin
        if (stb.handWr && stb.idx == IDX_W'(g)) handReg[g] <= stb.data;
        if (stb.prioWr && stb.idx == IDX_W'(g)) prioReg[g] <= stb.data[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (rdSel)
      RD_RAW:   rdMux = DATA_W'(rawReq);
      RD_IRQST: rdMux = DATA_W'(irqReq);
      RD_FIQST: rdMux = DATA_W'(fiqReq);
      RD_EN:    rdMux = DATA_W'(enReg);
      RD_ROUTE: rdMux = DATA_W'(routeReg);
      RD_SOFT:  rdMux = DATA_W'(softReg);
      RD_GATE:  rdMux = DATA_W'(gateReg);
      RD_LMASK: rdMux = DATA_W'(lvlMaskReg);
      RD_PRIV:  rdMux = DATA_W'(privOnly);
      RD_VEC:   rdMux = winValid ? handReg[winIdx[$clog2(NUM_SRC)-1:0]] : '0;
      RD_HAND:  rdMux = handReg[stb.idx[$clog2(NUM_SRC)-1:0]];
      RD_PRIO:  rdMux = DATA_W'(prioReg[stb.idx[$clog2(NUM_SRC)-1:0]]);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rData <= '0;
    else if (rdEn) rData <= rdMux;
  end

  // R3/R2: a normal request needs a gated, enabled, normal-routed live line
  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> |((srcIn | softReg) & enReg & gateReg & ~routeReg));

  // R6: a claim with a winner leaves that level marked in service
  assert_claim_marks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claim && winValid) |=> inService[$past(winPrio)]);

  // R6: the winner is strictly more urgent than every level in service
  assert_winner_above_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> ((inService & ((LVLS'(2) << winPrio) - LVLS'(1))) == '0));

  // R7: a retire removes exactly one in-service level
  assert_ack_clears_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !stb.claim && inService != '0) |=>
      ($countones(inService) + 1 == $countones($past(inService))));

  // R12: an empty claim leaves the in-service set as it was
  assert_empty_claim_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claim && !winValid && !stb.vecAck) |=> $stable(inService));
endmodule

// File: rtl/sec_vic.sv
module sec_vic
  import sec_vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [11:0]        busAddr,
  input  logic [31:0]        busWData,
  input  logic               busPriv,
  output logic [31:0]        busRData,
  output logic               irqOut,
  output logic               fiqOut
);
  strobe_t stb;
  rdSel_e  rdSel;
  logic    privOnly;

  sec_vic_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWData(busWData), .busPriv(busPriv), .stb(stb), .rdSel(rdSel),
    .privOnly(privOnly)
  );

  sec_vic_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .stb(stb), .rdSel(rdSel),
    .rdEn(busRd), .privOnly(privOnly), .rData(busRData),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/sec_vic_bench.sv
`timescale 1ns/1ps
module sec_vic_bench;
  logic        clk = 0, rstN = 0;
  logic [31:0] srcIn = 0;
  logic        busWr = 0, busRd = 0, busPriv = 1;
  logic [11:0] busAddr = 0;
  logic [31:0] busWData = 0;
  logic [31:0] busRData;
  logic        irqOut, fiqOut;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  sec_vic u_sec_vic (.clk(clk), .rstN(rstN), .srcIn(srcIn), .busWr(busWr),
    .busRd(busRd), .busAddr(busAddr), .busWData(busWData), .busPriv(busPriv),
    .busRData(busRData), .irqOut(irqOut), .fiqOut(fiqOut));

  // srcIn, expected irq, expected fiq, expected vector read
  typedef struct packed { logic [31:0] src; logic irq; logic fiq; logic [31:0] vec; } row_t;
  localparam row_t TABLE [7] = '{
    '{32'h0000_0006, 1'b1, 1'b0, 32'h1010},
    '{32'h0001_0001, 1'b1, 1'b0, 32'h1000},
    '{32'h0000_4200, 1'b1, 1'b0, 32'h10E0},
    '{32'h4000_0000, 1'b0, 1'b1, 32'h0},
    '{32'h8000_0020, 1'b1, 1'b1, 32'h1050},
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0},
    '{32'h0000_1088, 1'b1, 1'b0, 32'h1070}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic p = 1'b1);
    @(negedge clk);
    busWr = 1; busAddr = a; busWData = d; busPriv = p;
    @(negedge clk);
    busWr = 0; busPriv = 1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1; busAddr = a;
    @(negedge clk);
    busRd = 0;
    d = busRData;
  endtask

  task automatic setSrc(logic [31:0] s);
    @(negedge clk);
    srcIn = s;
    #1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irqOut}, 0);
    chk("R1 fiq", {31'b0, fiqOut}, 0);
    rd(12'h020, rv); chk("R1 gate", rv, 32'hFFFF_FFFF);
    rd(12'h00C, rv); chk("R1 enable", rv, 0);
    rd(12'h028, rv); chk("R1 privonly", rv, 0);

    for (int i = 0; i < 32; i++) begin
      wr(12'h200 + 12'(4 * i), 32'((i * 7) % 16));
      wr(12'h100 + 12'(4 * i), 32'h1000 + 32'(16 * i));
    end
    wr(12'h014, 32'hC000_0000);
    wr(12'h00C, 32'hFFFF_FFFF);

    // R5/R4 table walk
    for (int r = 0; r < 7; r++) begin
      setSrc(TABLE[r].src);
      chk("R5 irq", {31'b0, irqOut}, {31'b0, TABLE[r].irq});
      chk("R4 fiq", {31'b0, fiqOut}, {31'b0, TABLE[r].fiq});
      rd(12'h02C, rv); chk("R5 vector", rv, TABLE[r].vec);
      wr(12'h02C, 0);
    end

    // R2 gate
    wr(12'h020, 32'hFFFF_FFFD);
    setSrc(32'h2);
    chk("R2 gated irq", {31'b0, irqOut}, 0);
    rd(12'h000, rv); chk("R10 raw shows gated", rv, 32'h2);
    rd(12'h004, rv); chk("R2 masked status", rv, 0);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h004, rv); chk("R10 irq status", rv, 32'h2);

    // R6/R7 nesting
    setSrc(32'h6);
    rd(12'h02C, rv); chk("R6 first claim", rv, 32'h1010);
    #1 chk("R6 held off", {31'b0, irqOut}, 0);
    setSrc(32'h4000_0006);
    chk("R4 fiq during service", {31'b0, fiqOut}, 1);
    setSrc(32'h86);
    chk("R6 more urgent preempts", {31'b0, irqOut}, 1);
    rd(12'h02C, rv); chk("R6 nested claim", rv, 32'h1070);
    setSrc(32'h6);
    wr(12'h02C, 0);
    chk("R7 outer still held", {31'b0, irqOut}, 0);
    wr(12'h02C, 0);
    chk("R7 all retired", {31'b0, irqOut}, 1);
    rd(12'h02C, rv); chk("R7 reclaim", rv, 32'h1010);
    wr(12'h02C, 0);

    // R8 level mask
    wr(12'h024, 32'h80);
    setSrc(32'h2);
    chk("R8 masked level", {31'b0, irqOut}, 0);
    setSrc(32'h6);
    rd(12'h02C, rv); chk("R8 other level wins", rv, 32'h1020);
    wr(12'h02C, 0);
    wr(12'h024, 0);
    setSrc(0);

    // R9 soft trigger
    wr(12'h018, 32'h8);
    chk("R9 soft raises irq", {31'b0, irqOut}, 1);
    rd(12'h000, rv); chk("R9 raw soft", rv, 32'h8);
    rd(12'h02C, rv); chk("R9 soft vector", rv, 32'h1030);
    wr(12'h02C, 0);
    wr(12'h01C, 32'h8);
    chk("R9 soft cleared", {31'b0, irqOut}, 0);

    // R3 enable
    setSrc(32'h4000_0008);
    wr(12'h010, 32'h4000_0008);
    chk("R3 irq disabled", {31'b0, irqOut}, 0);
    chk("R3 fiq disabled", {31'b0, fiqOut}, 0);
    rd(12'h008, rv); chk("R10 fiq status", rv, 0);
    wr(12'h00C, 32'h4000_0008);
    chk("R3 re-enabled", {31'b0, irqOut}, 1);

    // R11 privilege
    wr(12'h028, 1);
    wr(12'h010, 32'hFFFF_FFFF, 1'b0);
    rd(12'h00C, rv); chk("R11 unpriv ignored", rv, 32'hFFFF_FFFF);
    chk("R11 irq kept", {31'b0, irqOut}, 1);
    wr(12'h010, 32'h8, 1'b1);
    rd(12'h00C, rv); chk("R11 priv write", rv, 32'hFFFF_FFF7);
    wr(12'h00C, 32'h8);

    // R12 empty vector read
    setSrc(0);
    rd(12'h02C, rv); chk("R12 empty vector", rv, 0);
    setSrc(32'h2);
    chk("R12 no level claimed", {31'b0, irqOut}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule